// File: doc/BRIEF.md
# Branch Target Instruction Cache

This block caches the opening instructions found at the destination of branches that have been taken before. The fetch unit presents the address of a branch it predicts taken. On a hit, the block returns the stored run of up to four target instruction words together with how many of them are valid. Fetch can then place those words in its instruction queue one cycle before an instruction-cache access would supply them.

The storage is 128 entries, arranged as 32 sets of four ways. The set comes from word-address bits [6:2] of the branch address, and the remaining upper bits form the tag. After a branch resolves, the allocate port writes or refreshes an entry. Replacement inside a set uses a three-bit tree pseudo-LRU. A single invalidate-all input empties the whole structure in one cycle.

Top module: `btc_top`

## Requirements
- R1: A lookup request sampled at a clock edge produces `rsp_valid_o` high for exactly the following cycle. `rsp_valid_o` is low after any edge where no lookup was requested.
- R2: A lookup hits when a valid way in set `lk_pc_i[6:2]` holds tag `lk_pc_i[31:7]`. The response then carries that way's stored count (1 to 4) and its stored words, with word 0 in bits [31:0] and word 3 in bits [127:96].
- R3: A lookup that misses reports `rsp_hit_o` low, `rsp_count_o` zero and `rsp_line_o` zero.
- R4: An allocate request with a count from 1 to 4 stores its tag, count and words so that later lookups hit. An allocate request with count 0 or count above 4 changes nothing.
- R5: An allocate whose tag already sits in a valid way of the target set rewrites that same way. A tag is never present twice in one set.
- R6: Victim choice for an allocate without a tag match: the lowest-numbered invalid way is taken first. If all four ways are valid, the set's tree state picks the way. The state has three bits {c,b,a}. a=0 selects ways 0/1 and then b picks way 1 when set, otherwise way 0. a=1 selects ways 2/3 and then c picks way 3 when set, otherwise way 2.
- R7: Each lookup hit and each accepted allocate updates the tree so that it points away from the touched way. Touching way 0 or 1 sets a=1 and sets b to 1 for way 0 or 0 for way 1. Touching way 2 or 3 clears a and sets c to 1 for way 2 or 0 for way 3. When a lookup hit and an accepted allocate target the same set in one cycle, only the allocate's update applies.
- R8: Invalidate-all empties every entry and returns every tree state to zero in one cycle. A lookup in that cycle misses, and an allocate in that cycle is dropped.
- R9: A lookup in the same cycle as an allocate sees the contents as they were before that allocate is written.
- R10: While reset is asserted, `rsp_valid_o` and `rsp_hit_o` are low and the cache holds no entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_all_i | input | 1 | Empty the whole cache |
| lk_req_i | input | 1 | Lookup request |
| lk_pc_i | input | 30 | Word address [31:2] of the branch being looked up |
| al_req_i | input | 1 | Allocate/update request |
| al_pc_i | input | 30 | Word address [31:2] of the resolved branch |
| al_count_i | input | 3 | Number of valid target words to store |
| al_line_i | input | 128 | Target words, word 0 in the low bits |
| rsp_valid_o | output | 1 | Lookup result valid |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_count_o | output | 3 | Valid target words on a hit, else 0 |
| rsp_line_o | output | 128 | Target words on a hit, else 0 |

## Verification
The assertions rely on two input conditions. Reset must be asserted before the first clock edge, and request and address inputs must carry known values whenever reset is released. A tag can only enter a set through the allocate port, which reuses a matching way, so the single-hit check needs no further input restriction. The stimulus changes inputs only shortly after a rising edge, through one driver task. That task keeps every input at zero during reset. It deliberately sends counts 0 and 5 and collides a lookup hit with an allocate in the same set, so the accepted and dropped cases both occur.

// File: rtl/btc_pkg.sv
`timescale 1ns/1ps
package btc_pkg;
  localparam int NUM_WAYS = 4;
  localparam int WAY_W    = 2;

  typedef logic [2:0]       plru_t;
  typedef logic [WAY_W-1:0] way_t;

  // bit 0 picks the half, bit 1 resolves ways 0/1, bit 2 resolves ways 2/3
  function automatic way_t plru_pick(plru_t s);
    if (!s[0]) return s[1] ? way_t'(1) : way_t'(0);
    else       return s[2] ? way_t'(3) : way_t'(2);
  endfunction

  function automatic plru_t plru_touch(plru_t s, way_t w);
    plru_t n;
    n = s;
    if (!w[1]) begin
      n[0] = 1'b1;
      n[1] = ~w[0];
    end else begin
      n[0] = 1'b0;
      n[2] = ~w[0];
    end
    return n;
  endfunction
endpackage

// File: rtl/btc_way.sv
`timescale 1ns/1ps
module btc_way #(
  parameter  int unsigned SETS   = 32,
  parameter  int unsigned TAG_W  = 25,
  parameter  int unsigned CNT_W  = 3,
  parameter  int unsigned LINE_W = 128,
  localparam int unsigned SET_W  = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              wr_en_i,
  input  logic [SET_W-1:0]  al_set_i,
  input  logic [TAG_W-1:0]  al_tag_i,
  input  logic [CNT_W-1:0]  wr_cnt_i,
  input  logic [LINE_W-1:0] wr_line_i,
  input  logic [SET_W-1:0]  lk_set_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  output logic              lk_hit_o,
  output logic [CNT_W-1:0]  lk_cnt_o,
  output logic [LINE_W-1:0] lk_line_o,
  output logic              al_vld_o,
  output logic              al_match_o
);
  logic [SETS-1:0]   vld_q, vld_d;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [CNT_W-1:0]  cnt_q  [SETS];
  logic [LINE_W-1:0] line_q [SETS];

  always_comb begin
    vld_d = vld_q;
    if (flush_i)      vld_d = '0;
    else if (wr_en_i) vld_d[al_set_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // payload arrays carry no reset; the valid bits qualify them
  always_ff @(posedge clk) begin
    if (wr_en_i && !flush_i) begin
      tag_q[al_set_i]  <= al_tag_i;
      cnt_q[al_set_i]  <= wr_cnt_i;
      line_q[al_set_i] <= wr_line_i;
    end
  end

  assign lk_hit_o   = vld_q[lk_set_i] && (tag_q[lk_set_i] == lk_tag_i);
  assign lk_cnt_o   = cnt_q[lk_set_i];
  assign lk_line_o  = line_q[lk_set_i];
  assign al_vld_o   = vld_q[al_set_i];
  assign al_match_o = vld_q[al_set_i] && (tag_q[al_set_i] == al_tag_i);

  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (vld_q == '0));

  p_write_fills_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !flush_i) |=> vld_q[$past(al_set_i)]);
endmodule

// File: rtl/btc_plru.sv
`timescale 1ns/1ps
module btc_plru import btc_pkg::*; #(
  parameter  int unsigned SETS  = 32,
  localparam int unsigned SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             lk_upd_i,
  input  logic [SET_W-1:0] lk_set_i,
  input  way_t             lk_way_i,
  input  logic             al_upd_i,
  input  logic [SET_W-1:0] al_set_i,
  input  way_t             al_way_i,
  output plru_t            al_state_o
);
  plru_t state_q [SETS];
  plru_t state_d [SETS];
  logic  lk_blocked;

  always_comb begin
    lk_blocked = al_upd_i && (al_set_i == lk_set_i);
    state_d    = state_q;
    if (flush_i) begin
      for (int i = 0; i < int'(SETS); i++) state_d[i] = '0;
    end else begin
      if (lk_upd_i && !lk_blocked)
        state_d[lk_set_i] = plru_touch(state_q[lk_set_i], lk_way_i);
      if (al_upd_i)
        state_d[al_set_i] = plru_touch(state_q[al_set_i], al_way_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(SETS); i++) state_q[i] <= '0;
    end else begin
      state_q <= state_d;
    end
  end

  assign al_state_o = state_q[al_set_i];

  p_alloc_protected_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (al_upd_i && !flush_i) |=> (plru_pick(state_q[$past(al_set_i)]) != $past(al_way_i)));

  p_hit_protected_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_upd_i && !flush_i && !(al_upd_i && (al_set_i == lk_set_i)))
      |=> (plru_pick(state_q[$past(lk_set_i)]) != $past(lk_way_i)));
endmodule

// File: rtl/btc_top.sv
`timescale 1ns/1ps
module btc_top import btc_pkg::*; #(
  parameter  int unsigned ADDR_W = 32,
  parameter  int unsigned INSN_W = 32,
  parameter  int unsigned SETS   = 32,
  parameter  int unsigned WORDS  = 4,
  localparam int unsigned SET_W  = $clog2(SETS),
  localparam int unsigned TAG_W  = ADDR_W - SET_W - 2,
  localparam int unsigned CNT_W  = $clog2(WORDS + 1),
  localparam int unsigned LINE_W = WORDS * INSN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_all_i,
  input  logic              lk_req_i,
  input  logic [ADDR_W-1:2] lk_pc_i,
  input  logic              al_req_i,
  input  logic [ADDR_W-1:2] al_pc_i,
  input  logic [CNT_W-1:0]  al_count_i,
  input  logic [LINE_W-1:0] al_line_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [CNT_W-1:0]  rsp_count_o,
  output logic [LINE_W-1:0] rsp_line_o
);
  logic [SET_W-1:0] lk_set, al_set;
  logic [TAG_W-1:0] lk_tag, al_tag;

  assign lk_set = lk_pc_i[SET_W+1:2];
  assign lk_tag = lk_pc_i[ADDR_W-1:SET_W+2];
  assign al_set = al_pc_i[SET_W+1:2];
  assign al_tag = al_pc_i[ADDR_W-1:SET_W+2];

  logic [NUM_WAYS-1:0] lk_hit_w, al_vld_w, al_match_w, wr_en_w;
  logic [CNT_W-1:0]    lk_cnt_w  [NUM_WAYS];
  logic [LINE_W-1:0]   lk_line_w [NUM_WAYS];

  logic  al_ok;
  way_t  al_way;
  plru_t al_state;

  assign al_ok = al_req_i && !inv_all_i && (al_count_i != '0)
              && (al_count_i <= CNT_W'(WORDS));

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
    assign wr_en_w[g] = al_ok && (al_way == way_t'(g));
    btc_way #(.SETS(SETS), .TAG_W(TAG_W), .CNT_W(CNT_W), .LINE_W(LINE_W)) i_way (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush_i   (inv_all_i),
      .wr_en_i   (wr_en_w[g]),
      .al_set_i  (al_set),
      .al_tag_i  (al_tag),
      .wr_cnt_i  (al_count_i),
      .wr_line_i (al_line_i),
      .lk_set_i  (lk_set),
      .lk_tag_i  (lk_tag),
      .lk_hit_o  (lk_hit_w[g]),
      .lk_cnt_o  (lk_cnt_w[g]),
      .lk_line_o (lk_line_w[g]),
      .al_vld_o  (al_vld_w[g]),
      .al_match_o(al_match_w[g])
    );
  end

  // way select for allocate: tag match, then lowest invalid, then tree
  always_comb begin
    al_way = plru_pick(al_state);
    for (int w = NUM_WAYS - 1; w >= 0; w--)
      if (!al_vld_w[w]) al_way = way_t'(w);
    for (int w = 0; w < NUM_WAYS; w++)
      if (al_match_w[w]) al_way = way_t'(w);
  end

  logic              lk_any;
  way_t              lk_way;
  logic [CNT_W-1:0]  lk_cnt_sel;
  logic [LINE_W-1:0] lk_line_sel;

  always_comb begin
    lk_way      = '0;
    lk_cnt_sel  = '0;
    lk_line_sel = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (lk_hit_w[w]) begin
        lk_way      = way_t'(w);
        lk_cnt_sel  = lk_cnt_sel | lk_cnt_w[w];
        lk_line_sel = lk_line_sel | lk_line_w[w];
      end
    end
  end

  assign lk_any = |lk_hit_w;

  btc_plru #(.SETS(SETS)) i_plru (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush_i   (inv_all_i),
    .lk_upd_i  (lk_req_i && lk_any),
    .lk_set_i  (lk_set),
    .lk_way_i  (lk_way),
    .al_upd_i  (al_ok),
    .al_set_i  (al_set),
    .al_way_i  (al_way),
    .al_state_o(al_state)
  );

  logic              rsp_valid_d, rsp_hit_d;
  logic [CNT_W-1:0]  rsp_cnt_d;
  logic [LINE_W-1:0] rsp_line_d;
  logic              rsp_valid_q, rsp_hit_q;
  logic [CNT_W-1:0]  rsp_cnt_q;
  logic [LINE_W-1:0] rsp_line_q;

  always_comb begin
    rsp_valid_d = lk_req_i;
    rsp_hit_d   = lk_req_i && lk_any && !inv_all_i;
    rsp_cnt_d   = rsp_hit_d ? lk_cnt_sel  : '0;
    rsp_line_d  = rsp_hit_d ? lk_line_sel : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_cnt_q   <= '0;
      rsp_line_q  <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_hit_q   <= rsp_hit_d;
      if (lk_req_i) begin
        rsp_cnt_q  <= rsp_cnt_d;
        rsp_line_q <= rsp_line_d;
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_hit_o   = rsp_hit_q;
  assign rsp_count_o = rsp_cnt_q;
  assign rsp_line_o  = rsp_line_q;

  p_one_way_hits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit_w));

  p_resp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req_i |=> rsp_valid_o);

  p_resp_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req_i |=> !rsp_valid_o);

  p_hit_count_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit_o |-> (rsp_valid_o && (rsp_count_o != '0) && (rsp_count_o <= CNT_W'(WORDS))));

  p_miss_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_hit_o) |-> ((rsp_count_o == '0) && (rsp_line_o == '0)));

  p_invalidate_misses_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all_i |=> !rsp_hit_o);

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |-> (!rsp_valid_o && !rsp_hit_o));
endmodule

// File: tb/test_btc_top.sv
`timescale 1ns/1ps
module test_btc_top;
  localparam int TW = 25;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         inv_all_i, lk_req_i, al_req_i;
  logic [31:2]  lk_pc_i, al_pc_i;
  logic [2:0]   al_count_i;
  logic [127:0] al_line_i;
  logic         rsp_valid_o, rsp_hit_o;
  logic [2:0]   rsp_count_o;
  logic [127:0] rsp_line_o;

  always #10 clk = ~clk;

  btc_top i_btc_top (
    .clk(clk), .rst_n(rst_n), .inv_all_i(inv_all_i),
    .lk_req_i(lk_req_i), .lk_pc_i(lk_pc_i),
    .al_req_i(al_req_i), .al_pc_i(al_pc_i), .al_count_i(al_count_i), .al_line_i(al_line_i),
    .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o),
    .rsp_count_o(rsp_count_o), .rsp_line_o(rsp_line_o)
  );

  typedef struct {
    bit           valid;
    bit           hit;
    logic [2:0]   cnt;
    logic [127:0] line;
    int           due;
    string        req;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_checks = 0;
  int n_errors = 0;

  // reference contents, built from the requirement text
  bit           m_vld  [32][4];
  logic [TW-1:0] m_tag [32][4];
  logic [2:0]   m_cnt  [32][4];
  logic [127:0] m_line [32][4];
  logic [2:0]   m_tree [32];

  function automatic int ref_victim(logic [2:0] s);
    if (s[0] == 1'b0) return (s[1] == 1'b1) ? 1 : 0;
    return (s[2] == 1'b1) ? 3 : 2;
  endfunction

  function automatic logic [2:0] ref_touch(logic [2:0] s, int w);
    logic [2:0] r;
    r = s;
    case (w)
      0: begin r[0] = 1'b1; r[1] = 1'b1; end
      1: begin r[0] = 1'b1; r[1] = 1'b0; end
      2: begin r[0] = 1'b0; r[2] = 1'b1; end
      default: begin r[0] = 1'b0; r[2] = 1'b0; end
    endcase
    return r;
  endfunction

  function automatic logic [127:0] mkline(int seed);
    return {32'(seed * 16 + 3) ^ 32'h3C00_0000, 32'(seed * 16 + 2) ^ 32'h5A00_0000,
            32'(seed * 16 + 1) ^ 32'h6900_0000, 32'(seed * 16) ^ 32'h7E00_0000};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit lk, input logic [TW-1:0] lt, input logic [4:0] ls,
                      input bit al, input logic [TW-1:0] at, input logic [4:0] aset,
                      input logic [2:0] ac, input logic [127:0] aline,
                      input bit inv, input string req);
    exp_t e;
    int   hw;
    int   aw;
    bit   aok;
    hw = 0;
    aw = 0;
    @(posedge clk);
    #2;
    lk_req_i   = lk;
    lk_pc_i    = {lt, ls};
    al_req_i   = al;
    al_pc_i    = {at, aset};
    al_count_i = ac;
    al_line_i  = aline;
    inv_all_i  = inv;
    e.valid = lk; e.hit = 1'b0; e.cnt = '0; e.line = '0;
    e.due = cyc + 1; e.req = req;
    if (lk && !inv) begin
      for (int w = 0; w < 4; w++) begin
        if (m_vld[ls][w] && m_tag[ls][w] == lt) begin
          e.hit = 1'b1; e.cnt = m_cnt[ls][w]; e.line = m_line[ls][w]; hw = w;
        end
      end
    end
    q.push_back(e);
    if (inv) begin
      for (int s = 0; s < 32; s++) begin
        m_tree[s] = '0;
        for (int w = 0; w < 4; w++) m_vld[s][w] = 1'b0;
      end
    end else begin
      aok = al && (ac >= 3'd1) && (ac <= 3'd4);
      if (lk && e.hit && !(aok && aset == ls)) m_tree[ls] = ref_touch(m_tree[ls], hw);
      if (aok) begin
        aw = ref_victim(m_tree[aset]);
        for (int w = 3; w >= 0; w--) if (!m_vld[aset][w]) aw = w;
        for (int w = 0; w < 4; w++) if (m_vld[aset][w] && m_tag[aset][w] == at) aw = w;
        m_vld[aset][aw]  = 1'b1;
        m_tag[aset][aw]  = at;
        m_cnt[aset][aw]  = ac;
        m_line[aset][aw] = aline;
        m_tree[aset]     = ref_touch(m_tree[aset], aw);
      end
    end
  endtask

  task automatic look(input logic [TW-1:0] t, input logic [4:0] s, input string req);
    step(1'b1, t, s, 1'b0, '0, '0, '0, '0, 1'b0, req);
  endtask

  task automatic put(input logic [TW-1:0] t, input logic [4:0] s, input logic [2:0] c,
                     input int seed, input string req);
    step(1'b0, '0, '0, 1'b1, t, s, c, mkline(seed), 1'b0, req);
  endtask

  task automatic idle();
    step(1'b0, '0, '0, 1'b0, '0, '0, '0, '0, 1'b0, "R1");
  endtask

  // monitor: compares each due item after the edge that produces it
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      cyc++;
      #12;
      if (rst_n === 1'b1) begin
        if (q.size() > 0 && q[0].due == cyc) begin
          e = q.pop_front();
          check("R1", "valid", 128'(rsp_valid_o), 128'(e.valid));
          if (e.valid) begin
            check(e.req, "hit",   128'(rsp_hit_o),   128'(e.hit));
            check(e.req, "count", 128'(rsp_count_o), 128'(e.cnt));
            check(e.req, "line",  rsp_line_o,        e.line);
          end
        end else if (rsp_valid_o !== 1'b0) begin
          check("R1", "unexpected valid", 128'(rsp_valid_o), 128'(0));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    rst_n = 1'b0;
    inv_all_i = 1'b0; lk_req_i = 1'b0; al_req_i = 1'b0;
    lk_pc_i = '0; al_pc_i = '0; al_count_i = '0; al_line_i = '0;
    for (int s = 0; s < 32; s++) begin
      m_tree[s] = '0;
      for (int w = 0; w < 4; w++) m_vld[s][w] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #5;
    check("R10", "reset valid", 128'(rsp_valid_o), 128'(0));
    check("R10", "reset hit",   128'(rsp_hit_o),   128'(0));
    @(negedge clk);
    rst_n = 1'b1;

    look(25'd1, 5'd0, "R3");
    put(25'd1, 5'd0, 3'd4, 1, "R4");
    look(25'd1, 5'd0, "R2");
    look(25'd1, 5'd1, "R3");

    put(25'd2, 5'd0, 3'd0, 2, "R4");
    put(25'd3, 5'd0, 3'd5, 3, "R4");
    look(25'd2, 5'd0, "R4");
    look(25'd3, 5'd0, "R4");
    look(25'd1, 5'd0, "R4");

    step(1'b1, 25'd4, 5'd2, 1'b1, 25'd4, 5'd2, 3'd3, mkline(4), 1'b0, "R9");
    look(25'd4, 5'd2, "R9");

    put(25'd1, 5'd0, 3'd2, 9, "R5");
    look(25'd1, 5'd0, "R5");
    put(25'd5, 5'd0, 3'd1, 5, "R6");
    put(25'd6, 5'd0, 3'd4, 6, "R6");
    put(25'd7, 5'd0, 3'd3, 7, "R6");
    put(25'd8, 5'd0, 3'd2, 8, "R6");
    for (int t = 1; t <= 8; t++) look(TW'(t), 5'd0, "R6");

    for (int t = 10; t <= 13; t++) put(TW'(t), 5'd5, 3'd4, t, "R7");
    look(25'd10, 5'd5, "R7");
    put(25'd14, 5'd5, 3'd2, 14, "R7");
    for (int t = 10; t <= 14; t++) look(TW'(t), 5'd5, "R7");

    for (int t = 20; t <= 23; t++) put(TW'(t), 5'd6, 3'd4, t, "R7");
    step(1'b1, 25'd23, 5'd6, 1'b1, 25'd24, 5'd6, 3'd3, mkline(24), 1'b0, "R7");
    put(25'd25, 5'd6, 3'd1, 25, "R7");
    for (int t = 20; t <= 25; t++) look(TW'(t), 5'd6, "R7");

    step(1'b1, 25'd1, 5'd0, 1'b1, 25'd30, 5'd7, 3'd2, mkline(30), 1'b1, "R8");
    look(25'd1, 5'd0, "R8");
    look(25'd30, 5'd7, "R8");
    look(25'd4, 5'd2, "R8");
    for (int t = 40; t <= 44; t++) put(TW'(t), 5'd0, 3'd4, t, "R8");
    for (int t = 40; t <= 44; t++) look(TW'(t), 5'd0, "R8");

    lf = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0], TW'(lf[3:1] % 3'd6), {3'b0, lf[5:4]},
           lf[6], TW'(lf[9:7] % 3'd6), {3'b0, lf[11:10]},
           3'(lf[14:12] % 3'd6), mkline(i + 100),
           (lf[15:11] == 5'd31), "R2");
    end

    repeat (3) idle();
    repeat (3) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule